// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames from a byte stream and scatters them into memory buffers. The buffers are described by a ring of 64-bit descriptors. After the payload it writes a 4-byte CRC-32. Frame data is split across buffers up to a programmable maximum buffer size. Each descriptor it uses is written back with the number of bytes it holds and its status bits. The block tracks whether reception is enabled and pulses an event for every closed buffer.

A descriptor word holds three fields:

- bits 63:32 hold the buffer byte address.
- bits 31:16 hold the status bits: empty is bit 31, wrap is bit 29, last is bit 27, length error is bit 21 and truncated is bit 16.
- bits 15:0 hold the byte count.

Descriptor reads are combinational: `dsc_rdata` must show the word at `dsc_addr` in the same cycle. Descriptor and data writes take effect at the clock edge.

The controller has seven states:

- ST_OFF: not receiving. It moves to ST_CHECK on a demand pulse while enabled.
- ST_CHECK: reads the descriptor at the pointer. It moves to ST_RECV if that descriptor is empty, otherwise back to ST_OFF.
- ST_RECV: accepts payload bytes. When a buffer fills it moves to ST_CLOSE. When the last payload byte arrives it moves to ST_CRC.
- ST_CRC: writes the four CRC bytes. When a buffer fills, or after the final CRC byte, it moves to ST_CLOSE.
- ST_CLOSE: writes the descriptor back and advances the pointer, then moves to ST_NEXT.
- ST_NEXT: reads the next descriptor. If that descriptor is empty it returns to ST_RECV or ST_CRC. If it is not empty, the block goes to ST_OFF when the frame is complete or its payload is already in. It goes to ST_DROP when payload bytes remain.
- ST_DROP: swallows the rest of the frame, then moves to ST_OFF.

From every state, dropping `ctl_enable` forces ST_OFF.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset `rx_active` and `in_ready` are low, and no descriptor write, data write or event occurs until a demand pulse.
- R2: A `rx_demand` pulse while `ctl_enable` is high and reception is off reads the descriptor at the pointer. If that descriptor has the empty bit (bit 31) set, `rx_active` and `in_ready` go high.
- R3: Payload bytes followed by the CRC-32 are stored back to back from the buffer address in bits 63:32. The CRC is reflected, uses polynomial 0x04C11DB7 and initial value all ones, is inverted at the end, and is stored most significant byte first.
- R4: Each buffer receives min(bytes left in frame including CRC, B) bytes. B is `cfg_buf_max` with bits 3:0 forced to zero.
- R5: When fewer than 4 bytes remain after a buffer fills, that buffer ends with the leading CRC bytes and the next buffer starts with the remaining ones.
- R6: Every used descriptor is written back with its byte count in bits 15:0 and the empty bit cleared; its other status bits are kept. The final descriptor of a frame also gets the last bit (27) and pulses `ev_rx_frame`. Each earlier descriptor pulses `ev_rx_buffer`.
- R7: A frame whose payload plus 4 exceeds `cfg_frame_limit` sets the length-error bit (21) on its final descriptor, with the truncated bit clear.
- R8: Payload bytes beyond FRAME_MAX-4 are accepted and discarded. The CRC covers only the kept bytes, and the final descriptor gets both the truncated bit (16) and the length-error bit.
- R9: After a descriptor with the wrap bit (29) set, the pointer returns to the ring base; otherwise it advances by 8. `ring_load` loads the ring base, whose bits 1:0 are forced to zero.
- R10: After a frame, if the next descriptor is not empty, `rx_active` and `in_ready` drop and stay low until a demand finds it empty.
- R11: If a non-empty descriptor is met in the middle of a frame, the rest of the frame is accepted and discarded. That descriptor is left untouched, no frame event is raised, and reception is off afterwards.
- R12: With `ctl_enable` low, `in_ready` and `rx_active` are low from the next cycle, and a demand has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Receive path enable |
| ring_load | input | 1 | Load ring pointer from base |
| rx_demand | input | 1 | Request to re-check the current descriptor |
| cfg_ring_base | input | 32 | Ring base address |
| cfg_frame_limit | input | 16 | User frame length limit |
| cfg_buf_max | input | 11 | Maximum buffer size (bits 3:0 ignored) |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Last payload byte of frame |
| in_ready | output | 1 | Stream byte accepted when high with valid |
| dsc_addr | output | 32 | Descriptor address (ring pointer) |
| dsc_rdata | input | 64 | Descriptor word at dsc_addr |
| dsc_we | output | 1 | Descriptor write-back strobe |
| dsc_wdata | output | 64 | Descriptor write-back word |
| dat_we | output | 1 | Data byte write strobe |
| dat_addr | output | 32 | Data byte address |
| dat_byte | output | 8 | Data byte |
| rx_active | output | 1 | Reception enabled |
| ev_rx_buffer | output | 1 | Pulse: non-final buffer closed |
| ev_rx_frame | output | 1 | Pulse: frame completed |

## Verification
The assertions assume four things about the inputs:

- The configuration inputs hold still while a frame is in flight.
- The masked buffer size is non-zero.
- Every frame carries at least one payload byte.
- `dsc_rdata` tracks `dsc_addr` within the cycle.

The bench keeps within these limits in three ways. It changes the configuration only between frames, after a settling gap. It always programs buffer sizes of 16 or 64. It serves descriptors from a combinational array model of the ring.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int AW    = 32;
    localparam int DSC_W = 64;
    localparam int FLG_EMPTY = 15;
    localparam int FLG_WRAP  = 13;
    localparam int FLG_LAST  = 11;
    localparam int FLG_LERR  = 5;
    localparam int FLG_TRUNC = 0;

    typedef enum logic [2:0] {
        ST_OFF, ST_CHECK, ST_RECV, ST_DROP, ST_CRC, ST_CLOSE, ST_NEXT
    } rxr_state_e;

    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int k = 0; k < 8; k++)
            r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction
endpackage

// File: rtl/rxr_crc_acc.sv
module rxr_crc_acc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] crc_out
);
    logic [31:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc <= '1;
        else if (clear)  acc <= '1;
        else if (en)     acc <= rxr_pkg::crc32_step(acc, data);
    end

    assign crc_out = ~acc;
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] base_al;
    assign base_al = {base[AW-1:2], 2'b00};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ptr <= '0;
        else if (load)     ptr <= base_al;
        else if (advance)  ptr <= wrap ? base_al : ptr + AW'(8);
    end

    always_ff @(posedge clk)
        if (rst_n) assert (ptr[1:0] == 2'b00) else $error("AST_PTR_ALIGN"); // R9
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int FRAME_MAX = 2048,
    parameter int LEN_W     = 16,
    parameter int BSZ_W     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_enable,
    input  logic              ring_load,
    input  logic              rx_demand,
    input  logic [AW-1:0]     cfg_ring_base,
    input  logic [LEN_W-1:0]  cfg_frame_limit,
    input  logic [BSZ_W-1:0]  cfg_buf_max,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic [AW-1:0]     dsc_addr,
    input  logic [DSC_W-1:0]  dsc_rdata,
    output logic              dsc_we,
    output logic [DSC_W-1:0]  dsc_wdata,
    output logic              dat_we,
    output logic [AW-1:0]     dat_addr,
    output logic [7:0]        dat_byte,
    output logic              rx_active,
    output logic              ev_rx_buffer,
    output logic              ev_rx_frame
);
    localparam logic [BSZ_W-1:0] BSZ_MASK = ~BSZ_W'(15);
    localparam logic [LEN_W-1:0] KEEP_MAX = LEN_W'(FRAME_MAX - 4);

    rxr_state_e      state, state_n;
    logic [AW-1:0]   buf_addr;
    logic [15:0]     cur_flags;
    logic [LEN_W-1:0] fill, pay_cnt, buf_lim;
    logic            trunc, in_crc, close_final;
    logic [1:0]      crc_idx;
    logic [31:0]     crc_val;
    logic            accept, room, fill_hit, dsc_empty, frame_clr, lerr;
    logic [15:0]     flags_wb;

    assign buf_lim   = LEN_W'(cfg_buf_max & BSZ_MASK);
    assign accept    = in_valid && in_ready;
    assign room      = pay_cnt < KEEP_MAX;
    assign fill_hit  = (fill + LEN_W'(1)) == buf_lim;
    assign dsc_empty = dsc_rdata[16 + FLG_EMPTY];
    assign frame_clr = (state == ST_OFF) || (state == ST_CHECK) ||
                       ((state == ST_CLOSE) && close_final);
    assign lerr      = trunc || (({1'b0, pay_cnt} + (LEN_W+1)'(4)) > {1'b0, cfg_frame_limit});

    rxr_crc_acc u_crc (
        .clk(clk), .rst_n(rst_n), .clear(frame_clr),
        .en(state == ST_RECV && accept && room),
        .data(in_data), .crc_out(crc_val)
    );

    rxr_ring_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ring_load), .base(cfg_ring_base),
        .advance(state == ST_CLOSE), .wrap(cur_flags[FLG_WRAP]), .ptr(dsc_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_n;
    end

    // next-state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_OFF:   if (rx_demand) state_n = ST_CHECK;
            ST_CHECK: state_n = dsc_empty ? ST_RECV : ST_OFF;
            ST_RECV:  if (accept) begin
                          if (room && fill_hit) state_n = ST_CLOSE;
                          else if (in_last)     state_n = ST_CRC;
                      end
            ST_DROP:  if (accept && in_last) state_n = ST_OFF;
            ST_CRC:   if (crc_idx == 2'd3 || fill_hit) state_n = ST_CLOSE;
            ST_CLOSE: state_n = ST_NEXT;
            ST_NEXT:  if (close_final)   state_n = dsc_empty ? ST_RECV : ST_OFF;
                      else if (dsc_empty) state_n = in_crc ? ST_CRC : ST_RECV;
                      else               state_n = in_crc ? ST_OFF : ST_DROP;
            default:  state_n = ST_OFF;
        endcase
        if (!ctl_enable) state_n = ST_OFF;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_addr <= '0; cur_flags <= '0; fill <= '0; pay_cnt <= '0;
            trunc <= 1'b0; in_crc <= 1'b0; crc_idx <= '0; close_final <= 1'b0;
            ev_rx_buffer <= 1'b0; ev_rx_frame <= 1'b0;
        end else begin
            ev_rx_buffer <= (state == ST_CLOSE) && !close_final;
            ev_rx_frame  <= (state == ST_CLOSE) &&  close_final;
            if (state_n == ST_CLOSE && state != ST_CLOSE)
                close_final <= (state == ST_CRC) && (crc_idx == 2'd3);
            if (frame_clr) begin
                pay_cnt <= '0; trunc <= 1'b0; in_crc <= 1'b0; crc_idx <= '0;
            end
            unique case (state)
                ST_CHECK, ST_NEXT: if (dsc_empty) begin
                    buf_addr  <= dsc_rdata[63:32];
                    cur_flags <= dsc_rdata[31:16];
                    fill      <= '0;
                end
                ST_RECV: if (accept) begin
                    if (room) begin
                        pay_cnt <= pay_cnt + LEN_W'(1);
                        fill    <= fill + LEN_W'(1);
                    end else begin
                        trunc <= 1'b1;
                    end
                    if (in_last) in_crc <= 1'b1;
                end
                ST_CRC: begin
                    fill    <= fill + LEN_W'(1);
                    crc_idx <= crc_idx + 2'd1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        flags_wb = cur_flags;
        flags_wb[FLG_EMPTY] = 1'b0;
        if (close_final) begin
            flags_wb[FLG_LAST]  = 1'b1;
            flags_wb[FLG_LERR]  = flags_wb[FLG_LERR] | lerr;
            flags_wb[FLG_TRUNC] = flags_wb[FLG_TRUNC] | trunc;
        end
        in_ready  = (state == ST_RECV) || (state == ST_DROP);
        rx_active = !(state == ST_OFF || state == ST_CHECK);
        dsc_we    = (state == ST_CLOSE);
        dsc_wdata = {buf_addr, flags_wb, fill[15:0]};
        dat_we    = (state == ST_RECV && accept && room) || (state == ST_CRC);
        dat_addr  = buf_addr + AW'(fill);
        dat_byte  = (state == ST_CRC) ? crc_val[8*(3-crc_idx) +: 8] : in_data;
    end

    AST_DISABLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |=> !in_ready && !rx_active) else $error("AST_DISABLE_READY"); // R12
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        dat_we |-> fill < buf_lim) else $error("AST_FILL_BOUND"); // R4
    AST_WB_EMPTY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_we |-> !dsc_wdata[16 + FLG_EMPTY]) else $error("AST_WB_EMPTY_CLR"); // R6
    AST_EVENT_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_we |=> (ev_rx_frame ^ ev_rx_buffer)) else $error("AST_EVENT_AFTER_WB"); // R6
    AST_TRUNC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV && trunc) |-> !dat_we) else $error("AST_TRUNC_NO_WRITE"); // R8
    AST_DROP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP) |-> !dsc_we && !dat_we) else $error("AST_DROP_NO_WB"); // R11
endmodule

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;
    localparam int FMAX = 96;
    localparam logic [31:0] BASE = 32'h100;

    logic clk = 0, rst_n = 0;
    logic ctl_enable = 0, ring_load = 0, rx_demand = 0;
    logic [31:0] cfg_ring_base = BASE;
    logic [15:0] cfg_frame_limit = 16'd1518;
    logic [10:0] cfg_buf_max = 11'd64;
    logic in_valid = 0, in_last = 0, in_ready;
    logic [7:0] in_data = 0;
    logic [31:0] dsc_addr, dat_addr;
    logic [63:0] dsc_rdata, dsc_wdata;
    logic dsc_we, dat_we, rx_active, ev_rx_buffer, ev_rx_frame;
    logic [7:0] dat_byte;

    logic [63:0] ring [0:7];
    logic [7:0]  mem  [0:4095];
    int n_rxb = 0, n_rxf = 0, n_chk = 0, n_fail = 0, cyc = 0;

    always #2.5 clk = ~clk;

    rxr_ring_writer #(.FRAME_MAX(FMAX)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ring_load(ring_load),
        .rx_demand(rx_demand), .cfg_ring_base(cfg_ring_base), .cfg_frame_limit(cfg_frame_limit),
        .cfg_buf_max(cfg_buf_max), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .dsc_addr(dsc_addr), .dsc_rdata(dsc_rdata), .dsc_we(dsc_we),
        .dsc_wdata(dsc_wdata), .dat_we(dat_we), .dat_addr(dat_addr), .dat_byte(dat_byte),
        .rx_active(rx_active), .ev_rx_buffer(ev_rx_buffer), .ev_rx_frame(ev_rx_frame)
    );

    always_comb begin
        int i;
        i = int'((dsc_addr - BASE) >> 3);
        dsc_rdata = (dsc_addr >= BASE && i < 8) ? ring[i] : 64'h0;
    end

    always @(posedge clk) begin
        cyc++;
        if (dsc_we) ring[int'((dsc_addr - BASE) >> 3)] <= dsc_wdata;
        if (dat_we) mem[dat_addr[11:0]] <= dat_byte;
        if (ev_rx_buffer) n_rxb++;
        if (ev_rx_frame)  n_rxf++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected < 100000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic settle(); repeat (12) @(negedge clk); endtask

    task automatic pulse_demand();
        @(negedge clk) rx_demand = 1; @(negedge clk) rx_demand = 0;
    endtask

    task automatic fill_ring(input int wrap_at);
        for (int i = 0; i < 8; i++)
            ring[i] = {32'h400 + 32'(i * 256), 16'h8000 | ((i == wrap_at) ? 16'h2000 : 16'h0), 16'h0};
    endtask

    function automatic logic [31:0] ref_crc(input int n, input int seed);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ 32'((seed + i) & 255);
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic send_frame(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1; in_data = 8'((seed + i) & 255); in_last = (i == len - 1);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk) in_valid = 0; in_last = 0;
        settle();
    endtask

    // walks the descriptors of one frame and checks counts, bits and bytes
    task automatic check_frame(input int first, input int kept, input int seed, input int bmax,
                               input logic lg, input logic tr, input string tag);
        int total = kept + 4;
        int off = 0;
        int idx = first;
        logic [31:0] c = ref_crc(kept, seed);
        while (off < total) begin
            int seg = (total - off < bmax) ? total - off : bmax;
            logic [63:0] d = ring[idx];
            logic fin = (off + seg == total);
            int bad = 0;
            logic [7:0] e;
            chk(d[15:0] == 16'(seg), tag, "byte count", d[15:0], seg);
            chk(!d[31] && d[27] == fin, tag, "empty/last bits", d[31:16], {fin, 4'h0});
            chk(d[21] == (fin & lg) && d[16] == (fin & tr), tag, "error bits",
                {d[21], d[16]}, {fin & lg, fin & tr});
            for (int k = 0; k < seg; k++) begin
                e = (off + k < kept) ? 8'((seed + off + k) & 255) : c[31 - 8*(off + k - kept) -: 8];
                if (mem[d[43:32] + 12'(k)] !== e) bad++;
            end
            chk(bad == 0, tag, "buffer bytes mismatched", bad, 0);
            idx = d[29] ? 0 : idx + 1;
            off += seg;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!rx_active && !in_ready && !dsc_we && !dat_we && !ev_rx_frame && !ev_rx_buffer,
            "R1", "idle outputs after reset", {rx_active, in_ready, dsc_we, dat_we}, 0);
    endtask

    task automatic t_basic();
        fill_ring(7);
        ctl_enable = 1;
        @(negedge clk) ring_load = 1; @(negedge clk) ring_load = 0;
        pulse_demand(); settle();
        chk(rx_active && in_ready, "R2", "active after demand on empty", {rx_active, in_ready}, 3);
        send_frame(10, 8'h10);
        check_frame(0, 10, 8'h10, 64, 0, 0, "R3 R6");
        chk(n_rxf == 1 && n_rxb == 0, "R6", "events single buffer", {n_rxf, n_rxb}, 64'h1_0000_0000);
    endtask

    task automatic t_split();
        cfg_buf_max = 11'h01F; settle();
        send_frame(30, 8'h40);
        check_frame(1, 30, 8'h40, 16, 0, 0, "R4 R5");
        chk(n_rxf == 2 && n_rxb == 2, "R6", "events three buffers", {n_rxf, n_rxb}, 64'h2_0000_0002);
        chk(ring[3][15:0] == 16'd2, "R5", "CRC tail buffer count", ring[3][15:0], 2);
    endtask

    task automatic t_limit();
        cfg_buf_max = 11'd64; cfg_frame_limit = 16'd20; settle();
        send_frame(20, 8'h70);
        check_frame(4, 20, 8'h70, 64, 1, 0, "R7");
        cfg_frame_limit = 16'd1518; settle();
        send_frame(16, 8'h90);
        check_frame(5, 16, 8'h90, 64, 0, 0, "R7");
    endtask

    task automatic t_trunc();
        send_frame(100, 8'hA0);
        check_frame(6, FMAX - 4, 8'hA0, 64, 1, 1, "R8");
    endtask

    task automatic t_wrap_reenable();
        chk(!rx_active && !in_ready, "R10", "off when next not empty", {rx_active, in_ready}, 0);
        pulse_demand(); settle();
        chk(!rx_active, "R10", "demand on full desc keeps off", rx_active, 0);
        ring[0] = {32'h400, 16'h8000, 16'h0};
        pulse_demand(); settle();
        chk(rx_active && in_ready, "R2", "re-enabled after demand", {rx_active, in_ready}, 3);
        send_frame(5, 8'h33);
        check_frame(0, 5, 8'h33, 64, 0, 0, "R9");
        chk(!rx_active, "R10", "off again after frame", rx_active, 0);
    endtask

    task automatic t_drop();
        int f0 = n_rxf, b0 = n_rxb;
        fill_ring(7);
        ring[1] = 64'h0000_0500_0000_ABCD;
        cfg_buf_max = 11'd16;
        @(negedge clk) ring_load = 1; @(negedge clk) ring_load = 0;
        pulse_demand(); settle();
        send_frame(30, 8'h55);
        chk(ring[0][15:0] == 16'd16 && !ring[0][27] && !ring[0][31], "R11", "first buffer closed non-final",
            ring[0][31:0], 32'h0000_0010);
        chk(ring[1] == 64'h0000_0500_0000_ABCD, "R11", "blocking desc untouched", ring[1], 64'h0000_0500_0000_ABCD);
        chk(n_rxf == f0 && n_rxb == b0 + 1, "R11", "events on drop", {n_rxf - f0, n_rxb - b0}, 1);
        chk(!rx_active && !in_ready, "R11", "off after drop", {rx_active, in_ready}, 0);
    endtask

    task automatic t_base_mask();
        fill_ring(7);
        cfg_buf_max = 11'd64; cfg_ring_base = BASE | 32'h3;
        @(negedge clk) ring_load = 1; @(negedge clk) ring_load = 0;
        pulse_demand(); settle();
        send_frame(5, 8'h77);
        check_frame(0, 5, 8'h77, 64, 0, 0, "R9");
    endtask

    task automatic t_disable();
        @(negedge clk) ctl_enable = 0;
        @(negedge clk);
        chk(!rx_active && !in_ready, "R12", "off after disable", {rx_active, in_ready}, 0);
        pulse_demand(); settle();
        chk(!rx_active && !in_ready, "R12", "demand ignored while disabled", {rx_active, in_ready}, 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        fill_ring(7);
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic();
        t_split();
        t_limit();
        t_trunc();
        t_wrap_reenable();
        t_drop();
        t_base_mask();
        t_disable();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule